// File: doc/BRIEF.md
# Banked Memory Decoder with Bank Register

This block is the address-decoding and bank-switching glue for an 8-bit CPU with a 16-bit address bus. It looks at the CPU address, the read/write line, the phase-2 qualifier and the data bus. From these it drives active-low selects for a RAM device, a ROM device and an I/O window. It also drives four extended physical address lines for the memory devices.

The lower 32KB of the address space always maps to RAM. A 1KB I/O window sits at `$8000-$83FF`. The remaining upper region, `$8400-$FFFF`, shows one bank whose source is chosen by an 8-bit bank register:

- Bit 7 picks the device: 0 selects ROM and 1 selects RAM.
- Bits 3:0 drive the extended address lines.
- Bits 6:4 are brought out as spare expansion lines.

The bank register sits at `$8000`. It is written by an ordinary CPU store. Reset clears the register, so code can be fetched from ROM bank 0 straight away.

Bus timing is modelled synchronously. A fast system clock samples the phase-2 strobe. The register commits the data seen in the last system-clock cycle of phase 2, on the first clock edge after phase 2 falls. All pins are plain level signals. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `bank_decoder`

## Requirements
- R1: After reset the bank register holds 0. A read in `$8400-$FFFF` then asserts `rom_cs_n` low, drives `ext_addr` = 0 and drives `spare_out` = 0.
- R2: Any access with `cpu_addr[15]` = 0 asserts only `ram_cs_n` and drives `ext_addr` = 0, whatever the register holds.
- R3: Addresses `$8001-$83FF` assert only `io_cs_n`. Address `$8000` asserts none of the three selects.
- R4: In `$8400-$FFFF`, register bit 7 = 1 asserts only `ram_cs_n` and bit 7 = 0 asserts only `rom_cs_n`. In both cases `ext_addr` equals register bits 3:0.
- R5: `spare_out` always equals register bits 6:4.
- R6: Register value `$80` maps an upper-region access to RAM with `ext_addr` = 0. This is the same physical RAM as the low 32KB, so it mirrors low RAM.
- R7: A write cycle to `$8000` (`cpu_rw` = 0 while `phi2` is high) loads the register once, on the first clock edge after `phi2` falls.
- R8: A read cycle (`cpu_rw` = 1) to `$8000` leaves the register unchanged.
- R9: The value loaded is the data bus as sampled in the last clock cycle of phase 2. Earlier, unsettled data is never stored.
- R10: At most one select is low at any time. No select is low during a write access while `phi2` is low.
- R11: A write to any address other than `$8000`, including `$8001`, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the phase-2 strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Phase-2 qualifier, high while data is valid |
| cpu_data | input | 8 | CPU data bus (write data) |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_cs_n | output | 1 | I/O window select, active low |
| ext_addr | output | 4 | Extended physical address lines (device A15-A18) |
| spare_out | output | 3 | Spare register bits 6:4 for expansion |

## Verification
The decode is probed with reads at both ends of the low RAM region, of the I/O window and of the banked region. This separates the range boundaries from the register address. Register values from three classes are used: ROM banks, RAM banks with set spare bits, and the `$80` mirror case. Each one separates the device choice, the bank lines and the spare lines from one another.

Register-load stimulus covers four cases:
- Writes whose data bus carries a different value early in phase 2, to show that only late data is stored.
- Reads to the register address.
- Write cycles in which `phi2` never rises.
- Writes to the neighbouring I/O address.

Each of these shows whether the load qualification is complete.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic [1:0] {
    RGN_LOW  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_BREG = 2'd2,
    RGN_BANK = 2'd3
  } region_e;
endpackage

// File: rtl/bank_region_decode.sv
module bank_region_decode
  import bank_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IO_LOG2 = 10,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int unsigned TAG_W = ADDR_W - IO_LOG2;

  logic upper, in_io;
  assign upper = addr[ADDR_W-1];
  assign in_io = (addr[ADDR_W-1:IO_LOG2] == IO_BASE[ADDR_W-1:IO_LOG2]);

  always_comb begin
    if (!upper)                region = RGN_LOW;
    else if (addr == REG_ADDR) region = RGN_BREG;
    else if (in_io)            region = RGN_IO;
    else                       region = RGN_BANK;
  end

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = IO_BASE[ADDR_W-1:IO_LOG2];
endmodule

// File: rtl/bank_register.sv
module bank_register
  import bank_dec_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cpu_rw,
  input  region_e           region,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] bank_q
);
  logic              hit_q;
  logic [DATA_W-1:0] data_q;

  // Track the latest phase-2 sample; commit once phase 2 has ended.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      data_q <= '0;
      bank_q <= '0;
    end else if (phi2) begin
      hit_q  <= (region == RGN_BREG) && !cpu_rw;
      data_q <= data;
    end else if (hit_q) begin
      bank_q <= data_q;
      hit_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_select_gen.sv
module bank_select_gen
  import bank_dec_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EXT_W  = 4
) (
  input  logic              a_top,
  input  logic              cpu_rw,
  input  logic              phi2,
  input  region_e           region,
  input  logic [DATA_W-1:0] bank_q,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              io_cs_n,
  output logic [EXT_W-1:0]  ext_addr,
  output logic [DATA_W-EXT_W-2:0] spare_out
);
  localparam int unsigned DEV_BIT = DATA_W - 1;

  logic en, use_ram;
  assign en      = cpu_rw | phi2;
  assign use_ram = bank_q[DEV_BIT];

  assign ram_cs_n = !(en && ((region == RGN_LOW) || (region == RGN_BANK && use_ram)));
  assign rom_cs_n = !(en && region == RGN_BANK && !use_ram);
  assign io_cs_n  = !(en && region == RGN_IO);

  for (genvar i = 0; i < EXT_W; i++) begin : g_ext
    assign ext_addr[i] = bank_q[i] & a_top;
  end

  assign spare_out = bank_q[DEV_BIT-1:EXT_W];
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned EXT_W   = 4,
  parameter int unsigned IO_LOG2 = 10,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              phi2,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic              io_cs_n,
  output logic [EXT_W-1:0]  ext_addr,
  output logic [DATA_W-EXT_W-2:0] spare_out
);
  region_e           region;
  logic [DATA_W-1:0] bank_q;

  bank_region_decode #(
    .ADDR_W(ADDR_W), .IO_LOG2(IO_LOG2), .IO_BASE(IO_BASE), .REG_ADDR(REG_ADDR)
  ) u_rgn (
    .addr(cpu_addr), .region(region)
  );

  bank_register #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_rw(cpu_rw),
    .region(region), .data(cpu_data), .bank_q(bank_q)
  );

  bank_select_gen #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_sel (
    .a_top(cpu_addr[ADDR_W-1]), .cpu_rw(cpu_rw), .phi2(phi2),
    .region(region), .bank_q(bank_q),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
    .ext_addr(ext_addr), .spare_out(spare_out)
  );
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EXT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rw,
  input logic              phi2,
  input logic              ram_cs_n,
  input logic              rom_cs_n,
  input logic              io_cs_n,
  input logic [EXT_W-1:0]  ext_addr,
  input logic [DATA_W-1:0] bank_q
);
  // R1: register is cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (bank_q == '0));

  // R2: low half never carries extended address bits
  a_r2_low_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[ADDR_W-1] |-> (ext_addr == '0));

  // R8: a cycle sampled as a read cannot lead to a register change
  a_r8_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_rw, 2) |-> $stable(bank_q));

  // R10: selects are exclusive
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ram_cs_n, ~rom_cs_n, ~io_cs_n}));

  // R10: no select on a write outside phase 2
  a_r10_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rw && !phi2) |-> (ram_cs_n && rom_cs_n && io_cs_n));
endmodule

bind bank_decoder bank_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_W(EXT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
  .phi2(phi2), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n),
  .ext_addr(ext_addr), .bank_q(bank_q)
);

// File: tb/bank_decoder_test.sv
module bank_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rw;
  logic        phi2;
  logic [7:0]  cpu_data;
  logic        ram_cs_n, rom_cs_n, io_cs_n;
  logic [3:0]  ext_addr;
  logic [2:0]  spare_out;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bank_decoder uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .phi2(phi2), .cpu_data(cpu_data), .ram_cs_n(ram_cs_n),
    .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n), .ext_addr(ext_addr),
    .spare_out(spare_out)
  );

  // sel encoding: {ram,rom,io} active-high
  task automatic check(string req, logic [2:0] e_sel, logic [3:0] e_ext, logic [2:0] e_sp);
    logic [2:0] a_sel;
    a_sel = {~ram_cs_n, ~rom_cs_n, ~io_cs_n};
    n_run++;
    if (a_sel !== e_sel || ext_addr !== e_ext || spare_out !== e_sp) begin
      n_fail++;
      $display("FAIL %s addr=%h: sel=%b ext=%h spare=%h, expected sel=%b ext=%h spare=%h",
               req, cpu_addr, a_sel, ext_addr, spare_out, e_sel, e_ext, e_sp);
    end
  endtask

  task automatic probe(logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rw = 1'b1; phi2 = 1'b1;
    #1;
  endtask

  // full bus cycle: early data differs from late data in phase 2
  task automatic bus_cycle(logic [15:0] a, logic rw, logic [7:0] d, logic with_phi2);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; phi2 = 1'b0; cpu_data = ~d;
    @(negedge clk);
    phi2 = with_phi2;
    @(negedge clk);
    cpu_data = d;
    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    cpu_rw = 1'b1; cpu_addr = 16'h0000;
  endtask

  task automatic write_reg(logic [7:0] v);
    bus_cycle(16'h8000, 1'b0, v, 1'b1);
  endtask

  task automatic t_reset;
    probe(16'h8400); check("R1", 3'b010, 4'h0, 3'd0);
  endtask

  task automatic t_low;
    write_reg(8'h8F);
    probe(16'h0000); check("R2", 3'b100, 4'h0, 3'd0);
    probe(16'h7FFF); check("R2", 3'b100, 4'h0, 3'd0);
  endtask

  task automatic t_io;
    probe(16'h8001); check("R3", 3'b001, 4'hF, 3'd0);
    probe(16'h83FF); check("R3", 3'b001, 4'hF, 3'd0);
    probe(16'h8000); check("R3", 3'b000, 4'hF, 3'd0);
  endtask

  task automatic t_banked;
    write_reg(8'h05);
    probe(16'hFFFF); check("R4 R7", 3'b010, 4'h5, 3'd0);
    write_reg(8'hC3);
    probe(16'h8400); check("R4 R5 R9", 3'b100, 4'h3, 3'd4);
    write_reg(8'h70);
    probe(16'hC000); check("R5", 3'b010, 4'h0, 3'd7);
  endtask

  task automatic t_mirror;
    write_reg(8'h80);
    probe(16'h9000); check("R6", 3'b100, 4'h0, 3'd0);
    probe(16'h1000); check("R6", 3'b100, 4'h0, 3'd0);
  endtask

  task automatic t_read_reg;
    write_reg(8'h2A);
    bus_cycle(16'h8000, 1'b1, 8'hFF, 1'b1);
    probe(16'h8400); check("R8", 3'b010, 4'hA, 3'd2);
  endtask

  task automatic t_gate;
    @(negedge clk);
    cpu_addr = 16'h0000; cpu_rw = 1'b0; phi2 = 1'b0;
    #1; check("R10", 3'b000, 4'h0, 3'd2);
    bus_cycle(16'h8000, 1'b0, 8'h81, 1'b0);
    probe(16'h8400); check("R7", 3'b010, 4'hA, 3'd2);
  endtask

  task automatic t_other;
    @(negedge clk);
    cpu_addr = 16'h8001; cpu_rw = 1'b0; phi2 = 1'b1;
    #1; check("R10", 3'b001, 4'hA, 3'd2);
    bus_cycle(16'h8001, 1'b0, 8'h80, 1'b1);
    probe(16'h8400); check("R11", 3'b010, 4'hA, 3'd2);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_rw = 1'b1; phi2 = 1'b0; cpu_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_low;
    t_io;
    t_banked;
    t_mirror;
    t_read_reg;
    t_gate;
    t_other;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule